// File: doc/BRIEF.md
# Paged Effective Address Generator

This block works out the address for one memory or I/O access per request. The instruction decoder selects an addressing mode and supplies the block's inputs: the register file values (BC, DE, HL, IX, IY), the address of the next instruction, up to three operand bytes and a restart vector index. The block returns a 24-bit address, a one-cycle valid strobe and a flag that marks an I/O cycle.

Two address widths are supported. In wide mode (`longMode` = 1), every register, program-counter value and sum is a full 24-bit quantity. In narrow mode, the 16-bit value that is computed is placed under an 8-bit page register (`pageReg`), which forms the top address byte. I/O accesses use a 16-bit port address with the top byte forced to zero.

The datapath is combinational and is followed by one output register. A small control unit decodes the mode. It then drives the datapath through a struct of strobes.

Top module: `ea_gen`

## Requirements
- R1: A request (`reqValid` = 1) with a mode code from 0 to 5 produces `addrValid` = 1 on the clock edge that samples it, and only for that cycle. Without a new request, `addrValid` returns to 0 on the next edge.
- R2: In narrow mode, modes 0 to 4 (memory accesses) place `pageReg` in `addrOut[23:16]`, and the computed 16-bit value in `addrOut[15:0]`.
- R3: Mode 0 (register indirect) uses `srcSel` to pick the base: 0 = BC, 1 = DE, 2 or 3 = HL. In wide mode the address is all 24 bits of that register. In narrow mode it is the register's low 16 bits.
- R4: Mode 1 (indexed) adds `opLo`, read as a signed byte (-128 to +127), to IX (`srcSel[0]` = 0) or to IY (`srcSel[0]` = 1). The sum wraps modulo 2^24 in wide mode, and modulo 2^16 in narrow mode before the page byte is attached.
- R5: Mode 2 (relative) adds the signed byte `opLo` to `nextPc`. It wraps in the same way as R4.
- R6: Mode 3 (extended) forms {`opHi`, `opMid`, `opLo`} in wide mode, with `opLo` as the least significant byte. In narrow mode it forms {`pageReg`, `opMid`, `opLo`}.
- R7: Mode 4 (restart) produces `rstIdx` × 8, a value from 00h to 38h. In wide mode, bits 23:8 are zero. In narrow mode the address is {`pageReg`, 00h, `rstIdx` × 8}.
- R8: Mode 5 (I/O) produces a 16-bit port address: `regBc[15:0]` when `srcSel[0]` = 0, or {`opMid`, `opLo`} when `srcSel[0]` = 1. `addrOut[23:16]` is 00h in both address widths, and `ioCycle` = 1 together with `addrValid`.
- R9: `ioCycle` is 0 in every cycle in which no I/O address is being delivered, including the cycles that follow memory-mode requests.
- R10: Mode codes 6 and 7 are ignored. No valid strobe follows them, and `addrOut` keeps its previous value.
- R11: `addrOut` changes only on a cycle that delivers a new address. Between requests it holds its value.
- R12: While `rstN` = 0, `addrOut` = 0, `addrValid` = 0 and `ioCycle` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe from the decoder |
| mode | input | 3 | Addressing mode code (0 to 5 used; 6 and 7 are reserved) |
| longMode | input | 1 | 1 = 24-bit wide mode, 0 = paged 16-bit mode |
| srcSel | input | 2 | Register choice for indirect, indexed and I/O modes |
| pageReg | input | 8 | Page byte used for narrow-mode memory addresses |
| regBc | input | 24 | BC register |
| regDe | input | 24 | DE register |
| regHl | input | 24 | HL register |
| regIx | input | 24 | IX index register |
| regIy | input | 24 | IY index register |
| nextPc | input | 24 | Address of the instruction after the current one |
| opLo | input | 8 | Operand byte 0 (least significant byte, or the displacement) |
| opMid | input | 8 | Operand byte 1 |
| opHi | input | 8 | Operand byte 2 |
| rstIdx | input | 3 | Restart vector index |
| addrOut | output | 24 | Registered effective address |
| addrValid | output | 1 | One-cycle strobe marking a new address |
| ioCycle | output | 1 | Set when the delivered address is an I/O port |

## Verification
Every result has the same latency. `addrOut`, `addrValid` and `ioCycle` take the value for a request on the first rising edge after the request is presented, and `addrValid` falls again on the edge after that. The bench drives each request on a falling edge, then reads all three outputs on the following falling edge, half a period after the capturing edge. On sampled requests it reads them once more a cycle later, which confirms that the strobe has fallen and the address is holding. Reserved codes are checked by looking for an absent strobe and an unchanged address one cycle after they are presented.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  localparam int EA_ADDR_W = 24;
  localparam int EA_OFS_W  = 16;
  localparam int EA_BYTE_W = 8;
  localparam int EA_IDX_W  = 3;

  typedef enum logic [2:0] {
    EA_INDIRECT = 3'd0,
    EA_INDEXED  = 3'd1,
    EA_RELATIVE = 3'd2,
    EA_EXTENDED = 3'd3,
    EA_RESTART  = 3'd4,
    EA_IO       = 3'd5
  } eaMode_e;

  typedef struct packed {
    logic       load;
    logic       selIndirect;
    logic       selIndexed;
    logic       selRelative;
    logic       selExtended;
    logic       selRestart;
    logic       selIo;
    logic       wide;
    logic [1:0] src;
  } eaStrobe_t;

endpackage

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] mode,
  input  logic       longMode,
  input  logic [1:0] srcSel,
  output eaStrobe_t  strb
);

  always_comb begin
    strb      = '0;
    strb.wide = longMode;
    strb.src  = srcSel;
    if (reqValid) begin
      unique case (mode)
        EA_INDIRECT: begin strb.load = 1'b1; strb.selIndirect = 1'b1; end
        EA_INDEXED:  begin strb.load = 1'b1; strb.selIndexed  = 1'b1; end
        EA_RELATIVE: begin strb.load = 1'b1; strb.selRelative = 1'b1; end
        EA_EXTENDED: begin strb.load = 1'b1; strb.selExtended = 1'b1; end
        EA_RESTART:  begin strb.load = 1'b1; strb.selRestart  = 1'b1; end
        EA_IO:       begin strb.load = 1'b1; strb.selIo       = 1'b1; end
        default:     strb.load = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ea_gen_dp.sv
module ea_gen_dp
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W = EA_ADDR_W,
  parameter int OFS_W  = EA_OFS_W,
  parameter int BYTE_W = EA_BYTE_W,
  parameter int IDX_W  = EA_IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  eaStrobe_t           strb,
  input  logic [ADDR_W-OFS_W-1:0] pageReg,
  input  logic [ADDR_W-1:0]   regBc,
  input  logic [ADDR_W-1:0]   regDe,
  input  logic [ADDR_W-1:0]   regHl,
  input  logic [ADDR_W-1:0]   regIx,
  input  logic [ADDR_W-1:0]   regIy,
  input  logic [ADDR_W-1:0]   nextPc,
  input  logic [BYTE_W-1:0]   opLo,
  input  logic [BYTE_W-1:0]   opMid,
  input  logic [BYTE_W-1:0]   opHi,
  input  logic [IDX_W-1:0]    rstIdx,
  output logic [ADDR_W-1:0]   addrOut,
  output logic                addrValid,
  output logic                ioCycle
);

  localparam int PAGE_W  = ADDR_W - OFS_W;
  localparam int EXT_W   = ADDR_W - BYTE_W;
  localparam int OPS_W   = 3 * BYTE_W;
  localparam int RST_SH  = 3;

  logic [ADDR_W-1:0] indBase, idxBase, dispBase, dispExt;
  logic [ADDR_W-1:0] sumLong, opWord, rstLong, memLong, nextAddr;
  logic [OFS_W-1:0]  sumShort, memShort, ioOfs, rstOfs;

  // Base register choices
  always_comb begin
    unique case (strb.src)
      2'd0:    indBase = regBc;
      2'd1:    indBase = regDe;
      default: indBase = regHl;
    endcase
  end

  assign idxBase  = strb.src[0] ? regIy : regIx;
  assign dispBase = strb.selRelative ? nextPc : idxBase;

  // Signed displacement adder, both widths
  assign dispExt  = {{EXT_W{opLo[BYTE_W-1]}}, opLo};
  assign sumLong  = dispBase + dispExt;
  assign sumShort = dispBase[OFS_W-1:0] + dispExt[OFS_W-1:0];

  // Operand assembly: the widest value the bytes can form, fitted to ADDR_W
  generate
    if (OPS_W >= ADDR_W) begin : g_opTrim
      logic [OPS_W-1:0] opsAll;
      assign opsAll = {opHi, opMid, opLo};
      assign opWord = opsAll[ADDR_W-1:0];
    end else begin : g_opPad
      assign opWord = {{(ADDR_W-OPS_W){1'b0}}, opHi, opMid, opLo};
    end
  endgenerate

  assign rstOfs  = OFS_W'(rstIdx) << RST_SH;
  assign rstLong = ADDR_W'(rstOfs);
  assign ioOfs   = strb.src[0] ? opWord[OFS_W-1:0] : regBc[OFS_W-1:0];

  always_comb begin
    memLong  = indBase;
    memShort = indBase[OFS_W-1:0];
    if (strb.selIndexed || strb.selRelative) begin
      memLong  = sumLong;
      memShort = sumShort;
    end else if (strb.selExtended) begin
      memLong  = opWord;
      memShort = opWord[OFS_W-1:0];
    end else if (strb.selRestart) begin
      memLong  = rstLong;
      memShort = rstOfs;
    end
  end

  always_comb begin
    if (strb.selIo)     nextAddr = {{PAGE_W{1'b0}}, ioOfs};
    else if (strb.wide) nextAddr = memLong;
    else                nextAddr = {pageReg, memShort};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut   <= '0;
      addrValid <= 1'b0;
      ioCycle   <= 1'b0;
    end else begin
      addrValid <= strb.load;
      ioCycle   <= strb.load & strb.selIo;
      if (strb.load) addrOut <= nextAddr;
    end
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W = EA_ADDR_W,
  parameter int OFS_W  = EA_OFS_W,
  parameter int BYTE_W = EA_BYTE_W,
  parameter int IDX_W  = EA_IDX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [2:0]              mode,
  input  logic                    longMode,
  input  logic [1:0]              srcSel,
  input  logic [ADDR_W-OFS_W-1:0] pageReg,
  input  logic [ADDR_W-1:0]       regBc,
  input  logic [ADDR_W-1:0]       regDe,
  input  logic [ADDR_W-1:0]       regHl,
  input  logic [ADDR_W-1:0]       regIx,
  input  logic [ADDR_W-1:0]       regIy,
  input  logic [ADDR_W-1:0]       nextPc,
  input  logic [BYTE_W-1:0]       opLo,
  input  logic [BYTE_W-1:0]       opMid,
  input  logic [BYTE_W-1:0]       opHi,
  input  logic [IDX_W-1:0]        rstIdx,
  output logic [ADDR_W-1:0]       addrOut,
  output logic                    addrValid,
  output logic                    ioCycle
);

  eaStrobe_t strb;

  ea_gen_ctrl u_ctrl (
    .reqValid (reqValid),
    .mode     (mode),
    .longMode (longMode),
    .srcSel   (srcSel),
    .strb     (strb)
  );

  ea_gen_dp #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .BYTE_W (BYTE_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pageReg   (pageReg),
    .regBc     (regBc),
    .regDe     (regDe),
    .regHl     (regHl),
    .regIx     (regIx),
    .regIy     (regIy),
    .nextPc    (nextPc),
    .opLo      (opLo),
    .opMid     (opMid),
    .opHi      (opHi),
    .rstIdx    (rstIdx),
    .addrOut   (addrOut),
    .addrValid (addrValid),
    .ioCycle   (ioCycle)
  );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [2:0]  mode,
  input logic        longMode,
  input logic [7:0]  pageReg,
  input logic [2:0]  rstIdx,
  input logic [23:0] addrOut,
  input logic        addrValid,
  input logic        ioCycle
);

  // R1
  req_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode <= 3'd5) |=> addrValid);

  // R1
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid);

  // R2
  page_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !longMode && mode <= 3'd4) |=> addrOut[23:16] == $past(pageReg));

  // R7
  restart_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && longMode && mode == 3'd4) |=> addrOut == {16'h0000, 2'b00, $past(rstIdx), 3'b000});

  // R8
  io_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioCycle |-> (addrValid && addrOut[23:16] == 8'h00));

  // R9
  io_memory_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode <= 3'd4) |=> !ioCycle);

  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode >= 3'd6) |=> (!addrValid && !ioCycle));

  // R11
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> $stable(addrOut));

  // R12
  always @(posedge clk) begin
    if (rstN && !$past(rstN)) begin
      reset_state_chk: assert (addrOut == 24'h0 && !addrValid && !ioCycle);
    end
  end

endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .mode      (mode),
  .longMode  (longMode),
  .pageReg   (pageReg),
  .rstIdx    (rstIdx),
  .addrOut   (addrOut),
  .addrValid (addrValid),
  .ioCycle   (ioCycle)
);

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic        longMode = 1'b0;
  logic [1:0]  srcSel = '0;
  logic [7:0]  pageReg = '0;
  logic [23:0] regBc = '0, regDe = '0, regHl = '0, regIx = '0, regIy = '0, nextPc = '0;
  logic [7:0]  opLo = '0, opMid = '0, opHi = '0;
  logic [2:0]  rstIdx = '0;
  logic [23:0] addrOut;
  logic        addrValid, ioCycle;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .longMode(longMode),
    .srcSel(srcSel), .pageReg(pageReg), .regBc(regBc), .regDe(regDe), .regHl(regHl),
    .regIx(regIx), .regIy(regIy), .nextPc(nextPc), .opLo(opLo), .opMid(opMid),
    .opHi(opHi), .rstIdx(rstIdx), .addrOut(addrOut), .addrValid(addrValid),
    .ioCycle(ioCycle)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  function automatic int sdisp(input logic [7:0] b);
    return (b >= 8'd128) ? int'(b) - 256 : int'(b);
  endfunction

  function automatic int fold(input int base, input int d, input logic wide, input logic [7:0] pg);
    if (wide) return (base + d + 32'h0100_0000) % 32'h0100_0000;
    return (int'(pg) * 65536) + (((base % 65536) + d + 65536) % 65536);
  endfunction

  function automatic int regPick(input logic [1:0] s);
    if (s == 2'd0) return int'(regBc);
    if (s == 2'd1) return int'(regDe);
    return int'(regHl);
  endfunction

  // Present one request, then sample one cycle later.
  task automatic issue(input logic [2:0] m, input logic [1:0] s, input int exp,
                       input logic expIo, input string req, input bit tail);
    @(negedge clk);
    mode = m; srcSel = s; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " valid"}, int'(addrValid), 1);
    check({req, " addr"}, int'(addrOut), exp);
    check({req, " io"}, int'(ioCycle), int'(expIo));
    if (tail) begin
      @(negedge clk);
      check("R1 strobe drops", int'(addrValid), 0);
      check("R11 addr holds", int'(addrOut), exp);
      check("R9 io low when idle", int'(ioCycle), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bases[4];
    logic [7:0] disps[7];
    bases = '{32'h00_0000, 32'h12_3456, 32'hFF_FFF0, 32'h00_FF90};
    disps = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h10, 8'hC3};

    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset addr", int'(addrOut), 0);
    check("R12 reset valid", int'(addrValid), 0);
    check("R12 reset io", int'(ioCycle), 0);
    rstN = 1'b1;

    regBc = 24'hA1B2C3; regDe = 24'h5D6E7F; regHl = 24'hFFEE01;
    for (int pgi = 0; pgi < 3; pgi++) begin
      pageReg = (pgi == 0) ? 8'h00 : (pgi == 1) ? 8'h7C : 8'hFF;
      for (int w = 0; w < 2; w++) begin
        longMode = w[0];
        // R3 register indirect, R2 page byte in narrow mode
        for (int s = 0; s < 4; s++) begin
          int e;
          e = w[0] ? regPick(2'(s)) : int'(pageReg) * 65536 + regPick(2'(s)) % 65536;
          issue(3'd0, 2'(s), e, 1'b0, w[0] ? "R3 indirect wide" : "R3/R2 indirect narrow", s == 3);
        end
        // R4 indexed sweep with wrap
        for (int b = 0; b < 4; b++) begin
          regIx = 24'(bases[b]); regIy = 24'(bases[3 - b]) ^ 24'h00_0101;
          for (int d = 0; d < 7; d++) begin
            opLo = disps[d];
            issue(3'd1, 2'd0, fold(int'(regIx), sdisp(opLo), w[0], pageReg), 1'b0, "R4 indexed IX", 1'b0);
            issue(3'd1, 2'd1, fold(int'(regIy), sdisp(opLo), w[0], pageReg), 1'b0, "R4 indexed IY", 1'b0);
            // R5 relative
            nextPc = 24'(bases[(b + d) % 4]);
            issue(3'd2, 2'd0, fold(int'(nextPc), sdisp(opLo), w[0], pageReg), 1'b0, "R5 relative", d == 6);
          end
        end
        // R6 extended
        for (int k = 0; k < 5; k++) begin
          opLo = 8'(8'h11 * k + 3); opMid = 8'(8'hF0 - 8'h21 * k); opHi = 8'(8'h5A + 8'h37 * k);
          issue(3'd3, 2'd0,
                w[0] ? int'({opHi, opMid, opLo}) : int'({pageReg, opMid, opLo}),
                1'b0, "R6 extended", k == 4);
        end
        // R7 restart, all eight vectors
        for (int r = 0; r < 8; r++) begin
          rstIdx = 3'(r);
          issue(3'd4, 2'd0, (w[0] ? 0 : int'(pageReg) * 65536) + r * 8, 1'b0, "R7 restart", r == 7);
        end
        // R8 I/O from BC and from operands, upper byte zero
        opLo = 8'h9A; opMid = 8'hBC;
        issue(3'd5, 2'd0, int'(regBc) % 65536, 1'b1, "R8 io from BC", 1'b1);
        issue(3'd5, 2'd1, 32'hBC9A, 1'b1, "R8 io from operands", 1'b1);
        // R9 memory request right after I/O clears the flag
        issue(3'd5, 2'd3, 32'hBC9A, 1'b1, "R8 io src3", 1'b0);
        issue(3'd3, 2'd0, w[0] ? int'({opHi, opMid, opLo}) : int'({pageReg, opMid, opLo}),
              1'b0, "R9 io cleared by memory", 1'b0);
      end
    end

    // R10 reserved codes ignored; address holds
    for (int m = 6; m < 8; m++) begin
      int held;
      held = int'(addrOut);
      @(negedge clk);
      mode = 3'(m); reqValid = 1'b1; regHl = 24'h135790;
      @(negedge clk);
      reqValid = 1'b0;
      check("R10 reserved no valid", int'(addrValid), 0);
      check("R10 reserved addr held", int'(addrOut), held);
      check("R10 reserved no io", int'(ioCycle), 0);
    end

    // R12 reset mid-run clears outputs
    issue(3'd0, 2'd2, 32'h135790, 1'b0, "R3 indirect pre-reset", 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R12 reset addr again", int'(addrOut), 0);
    check("R12 reset io again", int'(ioCycle), 0);
    rstN = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule